// File: doc/BRIEF.md
# Delayed Read Request Tracker

This block keeps a single delayed-read entry for the primary side of a bus bridge. When the primary master issues a memory read and the entry is free, the block captures the command, address and byte enables and answers with a retry. One cycle later it hands the secondary-side master a request that carries a prefetch length. When the secondary side reports that the data has arrived, the entry becomes complete.

Later requests from the primary side are compared against the held entry. A matching request finishes and frees the entry. Any other request is retried. Each of the three memory read commands has its own 2-bit prefetch mode. An optional relaxed match accepts a repeat that uses a different read command. In the extended split-transaction mode both the prefetch modes and the relaxed match are overridden.

Top module: `dly_rd_tracker`

## Requirements
- R1: After reset no response or forward is asserted. A request with command code 01 (plain read), 10 (read line) or 11 (read multiple) that arrives while the entry is free gets `req_retry_o` in that same cycle. The request is captured, and in the next cycle `fwd_valid_o` pulses with the captured command, address and byte enables.
- R2: While the entry is pending (forwarded but not yet done on the secondary side), every request is retried and nothing is forwarded.
- R3: Prefetch mode 00, and the reserved mode 01, forward the words left in the current cache line: LINE_W minus the word offset (address bits [log2(LINE_W)+1:2]). Disconnect is not flagged.
- R4: Prefetch mode 10 forwards the full requested length `req_len_i`.
- R5: Mode 11 on a plain read forwards a length of 1 with `fwd_disc_o` set.
- R6: Mode 11 on read line or read multiple is reserved and behaves as mode 00.
- R7: With `cfg_relax_i` low, a request on a complete entry finishes only if the command, address and byte enables all equal the captured ones. Otherwise it is retried.
- R8: With `cfg_relax_i` high and `cfg_split_i` low, a request on a complete entry with equal address and byte enables finishes (`req_done_o`) whatever its read command is.
- R9: With `cfg_split_i` high, the prefetch modes are ignored and the full requested length is forwarded without disconnect. `cfg_relax_i` is also ignored, so the command must match exactly.
- R10: A finishing request raises `req_done_o` for one cycle and never together with a retry. The entry is then free, so the next request is captured again.
- R11: If `sec_done_i` and a request fall in the same cycle while the entry is pending, the request is retried and the entry becomes complete at that edge.
- R12: A cycle with `req_valid_i` low, or with command code 00, produces no response and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_split_i | input | 1 | Primary side in extended split-transaction mode |
| cfg_relax_i | input | 1 | Allow a repeat with a different read command |
| cfg_pf_rd_i | input | 2 | Prefetch mode for plain read |
| cfg_pf_line_i | input | 2 | Prefetch mode for read line |
| cfg_pf_mult_i | input | 2 | Prefetch mode for read multiple |
| req_valid_i | input | 1 | Primary request present |
| req_cmd_i | input | 2 | Read command (00 none, 01 plain, 10 line, 11 multiple) |
| req_addr_i | input | AW | Request byte address |
| req_be_i | input | 4 | Request byte enables |
| req_len_i | input | LW | Requested length in words (at least 1) |
| req_retry_o | output | 1 | Request is retried this cycle |
| req_done_o | output | 1 | Request completes this cycle, entry freed |
| fwd_valid_o | output | 1 | Forwarded request for the secondary master |
| fwd_cmd_o | output | 2 | Forwarded command |
| fwd_addr_o | output | AW | Forwarded address |
| fwd_be_o | output | 4 | Forwarded byte enables |
| fwd_len_o | output | LW | Prefetch length in words |
| fwd_disc_o | output | 1 | Single-word transfer with disconnect |
| sec_done_i | input | 1 | Secondary read data has returned |

## Verification
Two events can fall in the same cycle: the secondary completion and a repeated primary request while the entry is pending. The bench forces this collision in a directed case and also produces it often at random, because it raises `sec_done_i` in about a third of the cycles while repeats arrive. The bench model answers the request from the state that held before the edge. So it expects a retry in the collision cycle, and expects the same request to finish in the following cycle.

// File: rtl/dly_rd_pkg.sv
package dly_rd_pkg;
  typedef enum logic [1:0] {CMD_NONE = 2'b00, CMD_RD = 2'b01, CMD_LINE = 2'b10, CMD_MULT = 2'b11} rd_cmd_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_CPL} ent_st_e;
  typedef enum logic [1:0] {PF_LINE = 2'b00, PF_RSVD = 2'b01, PF_FULL = 2'b10, PF_NONE = 2'b11} pf_mode_e;
endpackage

// File: rtl/dly_rd_pf_sel.sv
module dly_rd_pf_sel
  import dly_rd_pkg::*;
#(
  parameter int LW     = 8,
  parameter int LINE_W = 8,
  localparam int OFF_W = $clog2(LINE_W)
) (
  input  logic             split_i,
  input  logic [1:0]       cmd_i,
  input  logic [1:0]       pf_rd_i,
  input  logic [1:0]       pf_line_i,
  input  logic [1:0]       pf_mult_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [LW-1:0]    len_i,
  output logic [LW-1:0]    len_o,
  output logic             disc_o
);
  pf_mode_e     mode;
  logic [LW-1:0] line_rem;

  assign line_rem = LW'(LINE_W) - LW'(off_i);

  always_comb begin
    unique case (rd_cmd_e'(cmd_i))
      CMD_LINE: mode = pf_mode_e'(pf_line_i);
      CMD_MULT: mode = pf_mode_e'(pf_mult_i);
      default:  mode = pf_mode_e'(pf_rd_i);
    endcase
  end

  always_comb begin
    disc_o = 1'b0;
    len_o  = line_rem;
    if (split_i) begin
      len_o = len_i;
    end else begin
      unique case (mode)
        PF_FULL: len_o = len_i;
        PF_NONE: begin
          // single word only for plain read; reserved otherwise
          if (rd_cmd_e'(cmd_i) == CMD_RD) begin
            len_o  = LW'(1);
            disc_o = 1'b1;
          end
        end
        default: len_o = line_rem;
      endcase
    end
  end
endmodule

// File: rtl/dly_rd_match.sv
module dly_rd_match #(
  parameter int AW = 32
) (
  input  logic          split_i,
  input  logic          relax_i,
  input  logic [1:0]    ent_cmd_i,
  input  logic [AW-1:0] ent_addr_i,
  input  logic [3:0]    ent_be_i,
  input  logic [1:0]    req_cmd_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [3:0]    req_be_i,
  output logic          hit_o
);
  logic same_cmd, same_loc;

  assign same_cmd = (ent_cmd_i == req_cmd_i);
  assign same_loc = (ent_addr_i == req_addr_i) && (ent_be_i == req_be_i);
  assign hit_o    = same_loc && (same_cmd || (relax_i && !split_i));
endmodule

// File: rtl/dly_rd_tracker.sv
module dly_rd_tracker
  import dly_rd_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LW     = 8,
  parameter int LINE_W = 8,
  localparam int OFF_W = $clog2(LINE_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_split_i,
  input  logic          cfg_relax_i,
  input  logic [1:0]    cfg_pf_rd_i,
  input  logic [1:0]    cfg_pf_line_i,
  input  logic [1:0]    cfg_pf_mult_i,
  input  logic          req_valid_i,
  input  logic [1:0]    req_cmd_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [3:0]    req_be_i,
  input  logic [LW-1:0] req_len_i,
  output logic          req_retry_o,
  output logic          req_done_o,
  output logic          fwd_valid_o,
  output logic [1:0]    fwd_cmd_o,
  output logic [AW-1:0] fwd_addr_o,
  output logic [3:0]    fwd_be_o,
  output logic [LW-1:0] fwd_len_o,
  output logic          fwd_disc_o,
  input  logic          sec_done_i
);
  ent_st_e       st_q, st_d;
  logic [1:0]    ent_cmd_q;
  logic [AW-1:0] ent_addr_q;
  logic [3:0]    ent_be_q;
  logic          req_ok, hit, latch;
  logic [LW-1:0] pf_len;
  logic          pf_disc;

  assign req_ok = req_valid_i && (rd_cmd_e'(req_cmd_i) != CMD_NONE);

  dly_rd_pf_sel #(.LW(LW), .LINE_W(LINE_W)) u_pf (
    .split_i   (cfg_split_i),
    .cmd_i     (req_cmd_i),
    .pf_rd_i   (cfg_pf_rd_i),
    .pf_line_i (cfg_pf_line_i),
    .pf_mult_i (cfg_pf_mult_i),
    .off_i     (req_addr_i[OFF_W+1:2]),
    .len_i     (req_len_i),
    .len_o     (pf_len),
    .disc_o    (pf_disc)
  );

  dly_rd_match #(.AW(AW)) u_match (
    .split_i    (cfg_split_i),
    .relax_i    (cfg_relax_i),
    .ent_cmd_i  (ent_cmd_q),
    .ent_addr_i (ent_addr_q),
    .ent_be_i   (ent_be_q),
    .req_cmd_i  (req_cmd_i),
    .req_addr_i (req_addr_i),
    .req_be_i   (req_be_i),
    .hit_o      (hit)
  );

  always_comb begin
    st_d        = st_q;
    req_retry_o = 1'b0;
    req_done_o  = 1'b0;
    latch       = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_ok) begin
        req_retry_o = 1'b1;
        latch       = 1'b1;
        st_d        = ST_PEND;
      end
      ST_PEND: begin
        // response uses pre-edge state; completion takes effect at the edge
        req_retry_o = req_ok;
        if (sec_done_i) st_d = ST_CPL;
      end
      ST_CPL: if (req_ok) begin
        if (hit) begin
          req_done_o = 1'b1;
          st_d       = ST_IDLE;
        end else begin
          req_retry_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ent_cmd_q   <= '0;
      ent_addr_q  <= '0;
      ent_be_q    <= '0;
      fwd_valid_o <= 1'b0;
      fwd_cmd_o   <= '0;
      fwd_addr_o  <= '0;
      fwd_be_o    <= '0;
      fwd_len_o   <= '0;
      fwd_disc_o  <= 1'b0;
    end else begin
      st_q        <= st_d;
      fwd_valid_o <= latch;
      if (latch) begin
        ent_cmd_q  <= req_cmd_i;
        ent_addr_q <= req_addr_i;
        ent_be_q   <= req_be_i;
        fwd_cmd_o  <= req_cmd_i;
        fwd_addr_o <= req_addr_i;
        fwd_be_o   <= req_be_i;
        fwd_len_o  <= pf_len;
        fwd_disc_o <= pf_disc;
      end
    end
  end
endmodule

// File: rtl/dly_rd_tracker_chk.sv
module dly_rd_tracker_chk #(
  parameter int LW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [1:0]    req_cmd_i,
  input logic          req_retry_o,
  input logic          req_done_o,
  input logic          fwd_valid_o,
  input logic [LW-1:0] fwd_len_o,
  input logic          fwd_disc_o
);
  logic req_ok;
  assign req_ok = req_valid_i && (req_cmd_i != 2'b00);

  AST_REQ_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok |-> (req_retry_o || req_done_o)); // R1
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ok |-> !(req_retry_o || req_done_o)); // R12
  AST_FWD_AFTER_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> $past(req_retry_o)); // R1
  AST_DISC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && fwd_disc_o) |-> (fwd_len_o == LW'(1))); // R5
  AST_DONE_XOR_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_done_o && req_retry_o)); // R10
  AST_FREE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |=> !req_done_o); // R10
endmodule

bind dly_rd_tracker dly_rd_tracker_chk #(.LW(LW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_cmd_i   (req_cmd_i),
  .req_retry_o (req_retry_o),
  .req_done_o  (req_done_o),
  .fwd_valid_o (fwd_valid_o),
  .fwd_len_o   (fwd_len_o),
  .fwd_disc_o  (fwd_disc_o)
);

// File: tb/dly_rd_tracker_tb.sv
module dly_rd_tracker_tb;
  localparam int AW = 32;
  localparam int LW = 8;

  logic clk_i = 0, rst_ni = 0;
  logic cfg_split_i = 0, cfg_relax_i = 0;
  logic [1:0] cfg_pf_rd_i = 0, cfg_pf_line_i = 0, cfg_pf_mult_i = 0;
  logic req_valid_i = 0;
  logic [1:0] req_cmd_i = 0;
  logic [AW-1:0] req_addr_i = 0;
  logic [3:0] req_be_i = 0;
  logic [LW-1:0] req_len_i = 1;
  logic sec_done_i = 0;
  logic req_retry_o, req_done_o, fwd_valid_o, fwd_disc_o;
  logic [1:0] fwd_cmd_o;
  logic [AW-1:0] fwd_addr_o;
  logic [3:0] fwd_be_o;
  logic [LW-1:0] fwd_len_o;

  always #5 clk_i = ~clk_i;

  dly_rd_tracker #(.AW(AW), .LW(LW), .LINE_W(8)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  int m_st = 0; // 0 free, 1 pending, 2 complete
  int e_cmd, e_addr, e_be;
  bit e_fv = 0, e_disc = 0;
  int e_len = 0;
  string e_ftag = "R1";

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int pick_mode(int cmd);
    if (cmd == 2) return int'(cfg_pf_line_i);
    if (cmd == 3) return int'(cfg_pf_mult_i);
    return int'(cfg_pf_rd_i);
  endfunction

  function automatic int exp_len(int cmd, int addr, int len);
    int md = pick_mode(cmd);
    if (cfg_split_i) return len;
    if (md == 2) return len;
    if (md == 3 && cmd == 1) return 1;
    return 8 - ((addr >> 2) & 7);
  endfunction

  function automatic string len_tag(int cmd);
    int md = pick_mode(cmd);
    if (cfg_split_i) return "R9";
    if (md == 2) return "R4";
    if (md == 3) return (cmd == 1) ? "R5" : "R6";
    return "R3";
  endfunction

  task automatic step();
    bit ok, hit;
    int er, ed;
    string tag;
    @(negedge clk_i);
    chk(e_ftag, int'(fwd_valid_o), int'(e_fv), "fwd_valid");
    if (e_fv) begin
      chk(e_ftag, int'(fwd_len_o), e_len, "fwd_len");
      chk(e_ftag, int'(fwd_disc_o), int'(e_disc), "fwd_disc");
      chk("R1", int'(fwd_addr_o), e_addr, "fwd_addr");
      chk("R1", int'(fwd_cmd_o), e_cmd, "fwd_cmd");
      chk("R1", int'(fwd_be_o), e_be, "fwd_be");
    end
    ok = req_valid_i && req_cmd_i != 0;
    hit = (int'(req_addr_i) == e_addr) && (int'(req_be_i) == e_be) &&
          ((int'(req_cmd_i) == e_cmd) || (cfg_relax_i && !cfg_split_i));
    er = 0; ed = 0; tag = "R12";
    e_fv = 0;
    if (ok) begin
      if (m_st == 0) begin
        er = 1; tag = "R1";
        e_fv = 1; e_disc = 0;
        e_ftag = len_tag(int'(req_cmd_i));
        e_len = exp_len(int'(req_cmd_i), int'(req_addr_i), int'(req_len_i));
        if (!cfg_split_i && pick_mode(int'(req_cmd_i)) == 3 && req_cmd_i == 1) e_disc = 1;
        e_cmd = int'(req_cmd_i); e_addr = int'(req_addr_i); e_be = int'(req_be_i);
      end else if (m_st == 1) begin
        er = 1; tag = sec_done_i ? "R11" : "R2";
      end else begin
        if (hit) begin
          ed = 1; tag = (int'(req_cmd_i) != e_cmd) ? "R8" : "R10";
        end else begin
          er = 1; tag = cfg_split_i ? "R9" : "R7";
        end
      end
    end
    chk(tag, int'(req_retry_o), er, "retry");
    chk(tag, int'(req_done_o), ed, "done");
    if (m_st == 0 && ok) m_st = 1;
    else if (m_st == 1 && sec_done_i) m_st = 2;
    else if (m_st == 2 && ed == 1) m_st = 0;
    @(posedge clk_i); #1;
  endtask

  task automatic drive(int cmd, int addr, int be, int len, bit sd);
    req_valid_i = 1; req_cmd_i = 2'(cmd); req_addr_i = AW'(addr);
    req_be_i = 4'(be); req_len_i = LW'(len); sec_done_i = sd;
    step();
    req_valid_i = 0; sec_done_i = 0;
  endtask

  task automatic idle_cyc(bit sd);
    req_valid_i = 0; sec_done_i = sd;
    step();
    sec_done_i = 0;
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", int'(req_retry_o), 0, "reset retry");
    chk("R1", int'(fwd_valid_o), 0, "reset fwd_valid");
    chk("R1", int'(req_done_o), 0, "reset done");
    rst_ni = 1;
    @(posedge clk_i); #1;

    // R5: single-word plain read, then R11 collision, R7 strict, R8 relaxed
    cfg_pf_rd_i = 2'b11; cfg_pf_line_i = 2'b11;
    drive(1, 'h104, 'hF, 5, 0);
    drive(1, 'h104, 'hF, 5, 1);        // R11 retry in collision cycle
    drive(2, 'h104, 'hF, 5, 0);        // R7 different cmd, strict
    cfg_relax_i = 1;
    drive(2, 'h104, 'hF, 5, 0);        // R8 finishes
    drive(2, 'h11C, 'h3, 9, 0);        // R6 reserved line mode -> 1 word left
    idle_cyc(1);
    drive(2, 'h11C, 'h3, 9, 0);        // R10 finishes
    cfg_split_i = 1;
    drive(3, 'h200, 'hF, 20, 0);       // R9 full length
    idle_cyc(1);
    drive(1, 'h200, 'hF, 20, 0);       // R9 relax ignored -> retry
    drive(0, 'h200, 'hF, 20, 0);       // R12
    drive(3, 'h200, 'hF, 20, 0);
    cfg_split_i = 0; cfg_relax_i = 0;
    cfg_pf_rd_i = 2'b10; cfg_pf_line_i = 2'b00; cfg_pf_mult_i = 2'b01;

    for (int i = 0; i < 4000; i++) begin
      int addrs[4] = '{'h100, 'h104, 'h11C, 'h208};
      if (i % 40 == 0) begin
        cfg_split_i = ($urandom % 4) == 0;
        cfg_relax_i = $urandom % 2;
        cfg_pf_rd_i = 2'($urandom); cfg_pf_line_i = 2'($urandom); cfg_pf_mult_i = 2'($urandom);
      end
      req_valid_i = ($urandom % 3) != 0;
      req_cmd_i = 2'($urandom);
      if (m_st != 0 && ($urandom % 10) < 7) begin
        req_addr_i = AW'(e_addr); req_be_i = 4'(e_be);
      end else begin
        req_addr_i = AW'(addrs[$urandom % 4]); req_be_i = ($urandom % 2) ? 4'hF : 4'h3;
      end
      req_len_i = LW'(1 + $urandom % 32);
      sec_done_i = ($urandom % 3) == 0;
      step();
    end
    req_valid_i = 0; sec_done_i = 0;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule